// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block is a bus slave placed in front of a 32 MiB alias window. Every 32-bit word in that window stands for one bit of a backing memory region, so software can test, set or clear a single bit with one ordinary load or store. The bridge converts each alias access into a transfer on a simple master port toward the backing memory. An alias read fetches the addressed byte, halfword or word and returns only the selected bit. An alias write fetches the same unit, changes the one bit and writes the unit back.

The target region base is a parameter, so one instance can serve an on-chip RAM region (base 0x2000_0000, decoded by the interconnect at 0x2200_0000) and a second instance a peripheral region (base 0x4000_0000, decoded at 0x4200_0000). The slave port sees only the 25-bit offset into its window. The bridge handles one alias access at a time and holds the slave ready low until all master-side work for that access has completed.

Top module: `bitband_bridge`

## Requirements
- R1: A synchronous reset returns the sequencer to idle: in the cycle after reset, `m_req` and `s_ready` are both low and no master transfer is pending.
- R2: The master byte address is `TGT_BASE | (offset >> 5)`, where offset is the 25-bit slave address.
- R3: The access size code is 0 for byte, 1 for halfword and 2 for word. The bit index is `offset >> 2` masked to 3, 4 or 5 bits for those sizes. For a halfword, master address bit 0 is cleared. For a word, master address bits 1:0 are cleared. Bit n of a unit is bit n%8 of the byte at unit address + n/8 (little-endian).
- R4: A read returns 1 in result bit 0 when the selected bit is set and 0 otherwise. Result bits 31:1 are always zero. A read performs exactly one master read transfer.
- R5: A write performs a master read followed by a master write to the same address and size. The written unit equals the fetched unit with only the selected bit changed: set when write-data bit 0 is 1, cleared when it is 0.
- R6: Write-data bits 31:1 are ignored. They have no effect on the memory contents.
- R7: `s_ready` stays low until the master read (and, for writes, the write-back) has been acknowledged. It then pulses high for exactly one cycle, and only one alias access is in progress at a time.
- R8: While `m_req` is high and `m_ack` is low, the master request and its address, size, direction and write data hold steady.
- R9: Size code 3 behaves exactly like a word access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Alias access request, held until `s_ready` |
| s_we | input | 1 | 1 = alias write, 0 = alias read |
| s_size | input | 2 | Access size code (0 byte, 1 halfword, 2 or 3 word) |
| s_addr | input | 25 | Byte offset into the alias window |
| s_wdata | input | 32 | Write data; only bit 0 is used |
| s_rdata | output | 32 | Read result, valid while `s_ready` is high |
| s_ready | output | 1 | One-cycle completion pulse |
| m_req | output | 1 | Master transfer request |
| m_we | output | 1 | Master transfer direction, 1 = write |
| m_size | output | 2 | Master unit size (0 byte, 1 halfword, 2 word) |
| m_addr | output | 32 | Master byte address, aligned to the unit size |
| m_wdata | output | 32 | Master write unit, right-justified |
| m_rdata | input | 32 | Master read unit, right-justified, little-endian |
| m_ack | input | 1 | Master transfer completion |

## Verification
On every cycle the assertions check the following: unit alignment of the master address, stability of a stalled master request, the one-cycle shape of `s_ready`, that ready never overlaps a master request, zeroed upper read bits, and that a write-back differs from the fetched unit in at most one bit. Several properties can only be shown by the bench scenarios, because they depend on the data held in memory. These are whether the correct bit was picked or changed, whether the address arithmetic and little-endian mapping land on the right byte, whether write-data upper bits leave memory untouched, and how many master transfers each access costs. The bench covers them with random traffic against a reference memory, behind a stalling memory model.

// File: rtl/bitband_pkg.sv
package bitband_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } unit_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STORE = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/bitband_decode.sv
module bitband_decode
    import bitband_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          OFF_W    = 25,
    parameter int          BIT_W    = 5,
    parameter logic [31:0] TGT_BASE = 32'h2000_0000
) (
    input  logic [OFF_W-1:0]  offset,
    input  logic [1:0]        size_in,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [BIT_W-1:0]  bit_idx,
    output logic [1:0]        size_out
);
    localparam int SHIFT = BIT_W;

    logic [ADDR_W-1:0] raw_addr;
    logic [BIT_W-1:0]  raw_bit;

    always_comb begin
        raw_addr = ADDR_W'(TGT_BASE) | ADDR_W'(offset >> SHIFT);
        raw_bit  = offset[BIT_W+1:2];
        case (unit_size_e'(size_in))
            SZ_BYTE: begin
                tgt_addr = raw_addr;
                bit_idx  = raw_bit & BIT_W'(7);
                size_out = SZ_BYTE;
            end
            SZ_HALF: begin
                tgt_addr = raw_addr & ~ADDR_W'(1);
                bit_idx  = raw_bit & BIT_W'(15);
                size_out = SZ_HALF;
            end
            default: begin
                tgt_addr = raw_addr & ~ADDR_W'(3);
                bit_idx  = raw_bit;
                size_out = SZ_WORD;
            end
        endcase
    end

endmodule

// File: rtl/bitband_bitop.sv
module bitband_bitop #(
    parameter int DATA_W = 32,
    parameter int BIT_W  = 5
) (
    input  logic [DATA_W-1:0] unit_in,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic              new_val,
    output logic              picked,
    output logic [DATA_W-1:0] merged
);
    always_comb begin
        picked          = unit_in[bit_idx];
        merged          = unit_in;
        merged[bit_idx] = new_val;
    end

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bitband_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          DATA_W   = 32,
    parameter int          OFF_W    = 25,
    parameter logic [31:0] TGT_BASE = 32'h2000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    input  logic              s_we,
    input  logic [1:0]        s_size,
    input  logic [OFF_W-1:0]  s_addr,
    input  logic [DATA_W-1:0] s_wdata,
    output logic [DATA_W-1:0] s_rdata,
    output logic              s_ready,
    output logic              m_req,
    output logic              m_we,
    output logic [1:0]        m_size,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_ack
);
    localparam int BIT_W = $clog2(DATA_W);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [BIT_W-1:0]  bidx;
        logic [1:0]        size;
        logic              we;
        logic              setv;
        logic [DATA_W-1:0] unit;
    } regs_t;

    regs_t r_q, r_d;

    logic [ADDR_W-1:0] dec_addr;
    logic [BIT_W-1:0]  dec_bit;
    logic [1:0]        dec_size;
    logic              bit_picked;
    logic [DATA_W-1:0] unit_merged;

    bitband_decode #(
        .ADDR_W  (ADDR_W),
        .OFF_W   (OFF_W),
        .BIT_W   (BIT_W),
        .TGT_BASE(TGT_BASE)
    ) u_decode (
        .offset  (s_addr),
        .size_in (s_size),
        .tgt_addr(dec_addr),
        .bit_idx (dec_bit),
        .size_out(dec_size)
    );

    bitband_bitop #(
        .DATA_W(DATA_W),
        .BIT_W (BIT_W)
    ) u_bitop (
        .unit_in(r_q.unit),
        .bit_idx(r_q.bidx),
        .new_val(r_q.setv),
        .picked (bit_picked),
        .merged (unit_merged)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (s_valid) begin
                    r_d.st   = ST_FETCH;
                    r_d.addr = dec_addr;
                    r_d.bidx = dec_bit;
                    r_d.size = dec_size;
                    r_d.we   = s_we;
                    r_d.setv = s_wdata[0];
                end
            end
            ST_FETCH: begin
                if (m_ack) begin
                    r_d.unit = m_rdata;
                    r_d.st   = r_q.we ? ST_STORE : ST_DONE;
                end
            end
            ST_STORE: begin
                if (m_ack) r_d.st = ST_DONE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        m_req   = (r_q.st == ST_FETCH) || (r_q.st == ST_STORE);
        m_we    = (r_q.st == ST_STORE);
        m_addr  = r_q.addr;
        m_size  = r_q.size;
        m_wdata = (r_q.st == ST_STORE) ? unit_merged : '0;
        s_ready = (r_q.st == ST_DONE);
        s_rdata = (r_q.st == ST_DONE) ? DATA_W'(bit_picked) : '0;
    end

    // R1: the cycle after reset carries no request and no completion
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!m_req && !s_ready));

    // R3: master address aligned to its unit
    assert_unit_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        m_req |-> ((m_size == SZ_HALF) ? (m_addr[0] == 1'b0) :
                   (m_size == SZ_WORD) ? (m_addr[1:0] == 2'b00) : 1'b1));

    // R4: upper result bits are zero
    assert_rdata_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (s_rdata[DATA_W-1:1] == '0));

    // R5: write-back differs from the fetched unit in at most one bit
    assert_single_bit_change_R5: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_we) |-> ($countones(m_wdata ^ r_q.unit) <= 1));

    // R7: completion is a one-cycle pulse and never overlaps a master request
    assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        s_ready |=> !s_ready);
    assert_ready_no_req_R7: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> !m_req);

    // R8: a stalled master request holds steady
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_size) &&
                               $stable(m_we) && $stable(m_wdata)));

endmodule

// File: tb/bitband_bridge_test.sv
module bitband_bridge_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_valid = 1'b0;
    logic        s_we = 1'b0;
    logic [1:0]  s_size = 2'd0;
    logic [24:0] s_addr = '0;
    logic [31:0] s_wdata = '0;
    logic [31:0] s_rdata;
    logic        s_ready;
    logic        m_req;
    logic        m_we;
    logic [1:0]  m_size;
    logic [31:0] m_addr;
    logic [31:0] m_wdata;
    logic [31:0] m_rdata = '0;
    logic        m_ack = 1'b0;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    int rd_txn = 0;
    int wr_txn = 0;
    logic [31:0] last_rd_addr = '0;
    logic [31:0] last_wr_addr = '0;
    logic [1:0]  last_wr_size = '0;
    logic [7:0]  mem [0:255];
    logic [7:0]  refm [0:255];

    always #2.5 clk = ~clk;

    bitband_bridge uut (
        .clk(clk), .rst(rst),
        .s_valid(s_valid), .s_we(s_we), .s_size(s_size), .s_addr(s_addr),
        .s_wdata(s_wdata), .s_rdata(s_rdata), .s_ready(s_ready),
        .m_req(m_req), .m_we(m_we), .m_size(m_size), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack)
    );

    function automatic logic [7:0] seed_byte(int i);
        return 8'(i * 37 + 11);
    endfunction

    function automatic int nbytes(logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] exp_addr(logic [24:0] off, logic [1:0] s);
        logic [31:0] a;
        a = 32'h2000_0000 | 32'(off >> 5);
        return a & ~32'(nbytes(s) - 1);
    endfunction

    function automatic int exp_bit(logic [24:0] off, logic [1:0] s);
        return int'(off >> 2) & (nbytes(s) * 8 - 1);
    endfunction

    // Memory model with random stalls, one-cycle acknowledge
    always @(posedge clk) begin
        if (rst) begin
            m_ack <= 1'b0;
            for (int i = 0; i < 256; i++) mem[i] <= seed_byte(i);
        end else if (m_req && !m_ack && ($urandom % 4 != 0)) begin
            m_ack <= 1'b1;
            if (m_we) begin
                for (int i = 0; i < nbytes(m_size); i++)
                    mem[(m_addr[7:0] + 8'(i))] <= m_wdata[8*i +: 8];
                wr_txn <= wr_txn + 1;
                last_wr_addr <= m_addr;
                last_wr_size <= m_size;
            end else begin
                logic [31:0] v;
                v = '0;
                for (int i = 0; i < nbytes(m_size); i++)
                    v[8*i +: 8] = mem[(m_addr[7:0] + 8'(i))];
                m_rdata <= v;
                rd_txn <= rd_txn + 1;
                last_rd_addr <= m_addr;
            end
        end else begin
            m_ack <= 1'b0;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            $display("FAIL watchdog: actual=hung expected=finished");
            mismatched = mismatched + 1;
            compared = compared + 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [1:0] sz, input logic [24:0] off,
                          input logic [31:0] wd, output logic [31:0] rd, output int lat);
        s_valid = 1'b1; s_we = we; s_size = sz; s_addr = off; s_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!s_ready && lat < 1000);
        rd = s_rdata;
        s_valid = 1'b0;
        @(negedge clk);
        check("R7 ready drops after one cycle", 32'(s_ready), 32'd0);
    endtask

    task automatic run_one(logic we, logic [1:0] sz, logic [24:0] off, logic [31:0] wd);
        logic [31:0] rd;
        int lat, r0, w0, b, byte_i;
        logic [31:0] a;
        r0 = rd_txn; w0 = wr_txn;
        a = exp_addr(off, sz);
        b = exp_bit(off, sz);
        byte_i = int'(a[7:0]) + b / 8;
        access(we, sz, off, wd, rd, lat);
        check("R2/R3 master read address", last_rd_addr, a);
        if (!we) begin
            check("R4 read bit", rd, 32'(refm[byte_i & 255][b % 8]));
            check("R4 one master read", 32'(rd_txn - r0), 32'd1);
            check("R7 no write for read", 32'(wr_txn - w0), 32'd0);
        end else begin
            refm[byte_i & 255][b % 8] = wd[0];
            check("R5 write address", last_wr_addr, a);
            check("R5 write size", 32'(last_wr_size), 32'(sz == 2'd3 ? 2'd2 : sz));
            check("R5 read then write", 32'(rd_txn - r0) * 16 + 32'(wr_txn - w0), 32'h11);
            for (int k = 0; k < 4; k++)
                check("R5/R6 memory byte", 32'(mem[(int'(a[7:0]) + k) & 255]),
                      32'(refm[(int'(a[7:0]) + k) & 255]));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) refm[i] = seed_byte(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 no request after reset", 32'(m_req), 32'd0);
        check("R1 no ready after reset", 32'(s_ready), 32'd0);

        // Directed: byte, halfword, word, size code 3
        run_one(1'b0, 2'd0, 25'h0000_01C, 32'h0);
        run_one(1'b1, 2'd0, 25'h0000_01C, 32'h1);
        run_one(1'b0, 2'd0, 25'h0000_01C, 32'h0);
        run_one(1'b1, 2'd1, 25'h0000_07C, 32'hFFFF_FFFE);   // R6: upper ones, bit0 clears
        run_one(1'b1, 2'd2, 25'h0000_0FC, 32'h1);
        run_one(1'b0, 2'd2, 25'h0000_0FC, 32'h0);
        run_one(1'b1, 2'd3, 25'h0000_1E4, 32'h1);            // R9
        run_one(1'b0, 2'd3, 25'h0000_1E4, 32'h0);            // R9
        // R2: top of the window
        begin
            logic [31:0] rd; int lat;
            access(1'b0, 2'd2, 25'h1FF_FFFF, 32'h0, rd, lat);
            check("R2 window top address", last_rd_addr, 32'h200F_FFFC);
            check("R4 window top upper zero", rd & 32'hFFFF_FFFE, 32'h0);
        end

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [24:0] off;
            off = 25'($urandom % 8192);
            run_one(1'($urandom), 2'($urandom), off, $urandom);
        end

        // R1: reset during a pending access
        s_valid = 1'b1; s_we = 1'b1; s_size = 2'd2; s_addr = 25'h40; s_wdata = 32'h1;
        @(negedge clk);
        s_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 request cleared by reset", 32'(m_req), 32'd0);
        @(negedge clk);
        check("R1 stays idle", 32'(m_req) | 32'(s_ready), 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule